// File: doc/BRIEF.md
# Receive Packet Buffer with Commit and Rewind

This block is a single-clock packet buffer placed between a frame receiver and the application that consumes received frames. The receiver pushes 9-bit entries, each a data byte plus a last-byte flag. Entries land at a speculative write position and stay hidden from the reader until the receiver pulses commit. If the receiver decides the frame is bad, a rewind pulse throws away everything written since the last commit. The next write then lands directly after the last committed entry.

The receiver may also commit partway through a frame, for example once the frame is long enough that it can no longer be a runt. From that point until the entry that carries the last-byte flag, each accepted write is published to the reader at once, and a rewind can no longer remove any of it. Occupancy is counted from the speculative position, so full accounts for uncommitted entries as well. A write attempted while full raises a sticky overrun error. All writes are refused until the receiver pulses the clear input. The reader pops entries with a read enable and gets registered data one cycle later.

Top module: `pkt_commit_fifo`

## Requirements
- R1: While reset is held and just after it is released, empty is 1 and full, ovf_err and rd_valid are 0.
- R2: A popped entry returns the byte on rd_data[7:0] and its last-byte flag on rd_last. Entries come out in the order they were accepted.
- R3: An accepted write that is not yet committed is invisible to the reader. empty depends only on the committed region, so it stays 1 if only uncommitted entries are held.
- R4: When commit is pulsed in the same cycle as an accepted write, that entry belongs to the committed region.
- R5: A rewind pulse discards every entry accepted since the last commit, including one accepted in the same cycle. The next accepted write goes to the position directly after the last committed entry.
- R6: If commit leaves a packet open (its last-flag entry not yet written), each later accepted write of that packet is committed in its own cycle. This continues up to and including the last-flag entry. A rewind in this phase removes nothing.
- R7: full is 1 when DEPTH entries are held between the read position and the speculative write position, counting uncommitted ones. A write strobe while full and with no error pending is dropped and sets ovf_err on the next cycle.
- R8: ovf_err stays 1 until a cycle with err_clr high, after which it is 0 (unless a new overrun occurs in that cycle).
- R9: While ovf_err is 1, write strobes are ignored: nothing is stored and the write position does not move.
- R10: rd_en when empty is 0 pops one entry, and rd_valid is 1 with the entry on the next cycle. rd_en when empty is 1 is ignored, leaving rd_valid 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Byte to store |
| wr_last | input | 1 | Marks the last byte of a packet |
| commit | input | 1 | Publish everything written so far |
| rewind | input | 1 | Drop everything written since the last commit |
| err_clr | input | 1 | Clears the overrun error |
| full | output | 1 | No room for another entry |
| ovf_err | output | 1 | Sticky overrun error |
| rd_en | input | 1 | Pop request from the reader |
| rd_data | output | 8 | Popped byte, registered |
| rd_last | output | 1 | Last-byte flag of the popped entry |
| rd_valid | output | 1 | rd_data and rd_last hold a popped entry |
| empty | output | 1 | No committed entry is available |

## Verification
The assertions treat commit, rewind and err_clr as plain per-cycle levels that may coincide with each other and with a write. The pointer checks rely on a write and a rewind in the same cycle leaving the write position at the committed position. The bench deliberately breaks the receiver's duty not to write while full, so that overrun, blocked writes and clearing are all reached. It also keeps rewind rare enough that long runs fill the buffer. Random stimulus is mixed with directed packets that cover same-cycle commit, rewind after a mid-packet commit, and a completely full buffer whose contents are uncommitted.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

  // Distance from tail to head on a ring of 2**pw positions.
  function automatic int unsigned ring_used(int unsigned head, int unsigned tail,
                                            int unsigned pw);
    int unsigned mask;
    mask = (32'd1 << pw) - 32'd1;
    return (head - tail) & mask;
  endfunction

  function automatic logic ring_is_full(int unsigned used, int unsigned depth);
    return used == depth;
  endfunction

endpackage

// File: rtl/pcf_store.sv
module pcf_store #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned ENT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ENT_W-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [ENT_W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [ENT_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= cells[raddr];
  end

endmodule

// File: rtl/pcf_wr_ctrl.sv
module pcf_wr_ctrl #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_last,
  input  logic            commit,
  input  logic            rewind,
  input  logic            err_clr,
  input  logic [ADDR_W:0] rd_ptr,
  output logic [ADDR_W:0] spec_ptr,
  output logic [ADDR_W:0] cmt_ptr,
  output logic            wr_accept,
  output logic            full,
  output logic            ovf_err
);
  localparam int unsigned PW    = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic          pkt_open, stream_on;
  logic          overrun_ev;
  logic [PW-1:0] spec_adv, cmt_nxt;
  logic          open_nxt;
  int unsigned   used;

  assign used       = pcf_pkg::ring_used(32'(spec_ptr), 32'(rd_ptr), PW);
  assign full       = pcf_pkg::ring_is_full(used, DEPTH);
  assign wr_accept  = wr_en && !full && !ovf_err;
  assign overrun_ev = wr_en && full && !ovf_err;

  assign spec_adv = wr_accept ? spec_ptr + PW'(1) : spec_ptr;
  assign cmt_nxt  = (commit || (stream_on && wr_accept)) ? spec_adv : cmt_ptr;
  assign open_nxt = rewind ? 1'b0 : (wr_accept ? !wr_last : pkt_open);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spec_ptr  <= '0;
      cmt_ptr   <= '0;
      pkt_open  <= 1'b0;
      stream_on <= 1'b0;
      ovf_err   <= 1'b0;
    end else begin
      cmt_ptr  <= cmt_nxt;
      spec_ptr <= rewind ? cmt_nxt : spec_adv;
      pkt_open <= open_nxt;
      if (rewind)                      stream_on <= 1'b0;
      else if (commit)                 stream_on <= open_nxt;
      else if (wr_accept && wr_last)   stream_on <= 1'b0;
      if (overrun_ev)                  ovf_err <= 1'b1;
      else if (err_clr)                ovf_err <= 1'b0;
    end
  end

  a_r3_cmt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !(stream_on && wr_accept)) |=> $stable(cmt_ptr));
  a_r4_commit_incl: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_accept) |=> cmt_ptr == $past(spec_ptr) + PW'(1));
  a_r5_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind && !commit && !wr_accept) |=> spec_ptr == $past(cmt_ptr));
  a_r6_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_on && wr_accept) |=> cmt_ptr == spec_ptr);
  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !ovf_err) |=> ovf_err);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    used <= DEPTH);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !err_clr) |=> ovf_err);
  a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> !wr_accept);

endmodule

// File: rtl/pcf_rd_ctrl.sv
module pcf_rd_ctrl #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   cmt_ptr,
  output logic [ADDR_W:0]   rd_ptr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_fire,
  output logic              empty,
  output logic              rd_valid
);
  localparam int unsigned PW    = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  int unsigned avail;

  assign avail   = pcf_pkg::ring_used(32'(cmt_ptr), 32'(rd_ptr), PW);
  assign empty   = (avail == 0);
  assign rd_fire = rd_en && !empty;
  assign rd_addr = rd_ptr[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_ptr <= rd_ptr + PW'(1);
    end
  end

  a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> !rd_valid);
  a_r10_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty) |=> rd_valid);
  a_r3_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
    avail <= DEPTH);

endmodule

// File: rtl/pkt_commit_fifo.sv
module pkt_commit_fifo #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              commit,
  input  logic              rewind,
  input  logic              err_clr,
  output logic              full,
  output logic              ovf_err,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_last,
  output logic              rd_valid,
  output logic              empty
);
  localparam int unsigned ENT_W = BYTE_W + 1;

  logic [ADDR_W:0]   spec_ptr, cmt_ptr, rd_ptr;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_accept, rd_fire;
  logic [ENT_W-1:0]  rd_word;

  pcf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_last(wr_last),
    .commit(commit), .rewind(rewind), .err_clr(err_clr), .rd_ptr(rd_ptr),
    .spec_ptr(spec_ptr), .cmt_ptr(cmt_ptr), .wr_accept(wr_accept),
    .full(full), .ovf_err(ovf_err)
  );

  pcf_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .cmt_ptr(cmt_ptr),
    .rd_ptr(rd_ptr), .rd_addr(rd_addr), .rd_fire(rd_fire),
    .empty(empty), .rd_valid(rd_valid)
  );

  pcf_store #(.ADDR_W(ADDR_W), .ENT_W(ENT_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(wr_accept), .waddr(spec_ptr[ADDR_W-1:0]),
    .wdata({wr_last, wr_data}), .re(rd_fire), .raddr(rd_addr), .rdata(rd_word)
  );

  assign rd_data = rd_word[BYTE_W-1:0];
  assign rd_last = rd_word[BYTE_W];

endmodule

// File: tb/pkt_commit_fifo_tb_top.sv
module pkt_commit_fifo_tb_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_last = 0, commit = 0, rewind = 0, err_clr = 0, rd_en = 0;
  logic [7:0] wr_data = '0;
  logic full, ovf_err, rd_last, rd_valid, empty;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model, unbounded positions
  logic [8:0] m_mem [DEPTH];
  int m_spec = 0, m_cmt = 0, m_rd = 0;
  bit m_err = 0, m_open = 0, m_stream = 0, e_valid = 0;
  logic [8:0] e_word = '0;

  always #5 clk = ~clk;

  pkt_commit_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
    .commit(commit), .rewind(rewind), .err_clr(err_clr), .full(full),
    .ovf_err(ovf_err), .rd_en(rd_en), .rd_data(rd_data), .rd_last(rd_last),
    .rd_valid(rd_valid), .empty(empty)
  );

  function automatic bit mdl_full();
    return (m_spec - m_rd) == DEPTH;
  endfunction
  function automatic bit mdl_empty();
    return m_cmt == m_rd;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit acc, ovr, rok;
    int adv, cnx;
    acc = wr_en && !mdl_full() && !m_err;
    ovr = wr_en && mdl_full() && !m_err;
    rok = rd_en && !mdl_empty();
    e_valid = rok;
    if (rok) begin
      e_word = m_mem[m_rd % DEPTH];
      m_rd++;
    end
    if (acc) m_mem[m_spec % DEPTH] = {wr_last, wr_data};
    adv = acc ? m_spec + 1 : m_spec;
    cnx = (commit || (m_stream && acc)) ? adv : m_cmt;
    if (rewind) m_stream = 0;
    else if (commit) m_stream = acc ? !wr_last : m_open;
    else if (acc && wr_last) m_stream = 0;
    if (rewind) m_open = 0;
    else if (acc) m_open = !wr_last;
    m_cmt = cnx;
    m_spec = rewind ? cnx : adv;
    if (ovr) m_err = 1;
    else if (err_clr) m_err = 0;
  endtask

  task automatic compare(string req);
    chk({req, "/R3"}, "empty", empty, mdl_empty());
    chk({req, "/R7"}, "full", full, mdl_full());
    chk({req, "/R8"}, "ovf_err", ovf_err, m_err);
    chk({req, "/R10"}, "rd_valid", rd_valid, e_valid);
    if (e_valid) begin
      chk({req, "/R2"}, "rd_data", rd_data, e_word[7:0]);
      chk({req, "/R2"}, "rd_last", rd_last, e_word[8]);
    end
  endtask

  task automatic step(string req, bit w, logic [7:0] d, bit l, bit c, bit rw,
                      bit cl, bit r);
    wr_en = w; wr_data = d; wr_last = l; commit = c; rewind = rw;
    err_clr = cl; rd_en = r;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(req);
  endtask

  task automatic drain(string req);
    while (!mdl_empty()) step(req, 0, 8'h00, 0, 0, 0, 0, 1);
    step(req, 0, 8'h00, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R1", "empty", empty, 1); chk("R1", "full", full, 0);
    chk("R1", "ovf_err", ovf_err, 0); chk("R1", "rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "empty after release", empty, 1);
    chk("R1", "ovf_err after release", ovf_err, 0);

    // R3: uncommitted data hidden; R10: read on empty ignored
    for (int i = 0; i < 3; i++) step("R3", 1, 8'h10 + 8'(i), 0, 0, 0, 0, 1);
    chk("R3", "empty with uncommitted", empty, 1);
    // R4: commit with last write in same cycle
    step("R4", 1, 8'h13, 1, 1, 0, 0, 0);
    chk("R4", "empty after commit", empty, 0);
    drain("R4");

    // R5: rewind drops packet, next write lands after committed data
    step("R5", 1, 8'hA0, 0, 0, 0, 0, 0);
    step("R5", 1, 8'hA1, 0, 0, 1, 0, 0);
    chk("R5", "empty after rewind", empty, 1);
    step("R5", 1, 8'hB0, 0, 0, 0, 0, 0);
    step("R5", 1, 8'hB1, 1, 1, 0, 0, 0);
    step("R5", 0, 8'h00, 0, 0, 0, 0, 1);
    chk("R5", "first byte after rewind", rd_data, 8'hB0);
    drain("R5");

    // R6: early commit, streaming bytes, rewind removes nothing
    for (int i = 0; i < 3; i++) step("R6", 1, 8'hC0 + 8'(i), 0, 0, 0, 0, 0);
    step("R6", 0, 8'h00, 0, 1, 0, 0, 0);
    drain("R6");
    step("R6", 1, 8'hC3, 0, 0, 0, 0, 0);
    chk("R6", "streamed byte visible", empty, 0);
    step("R6", 1, 8'hC4, 1, 0, 0, 0, 0);
    step("R6", 0, 8'h00, 0, 0, 1, 0, 0);
    chk("R6", "rewind kept streamed", empty, 0);
    drain("R6");

    // R7: full counts uncommitted entries; overrun; R9 blocked; R8 clear
    for (int i = 0; i < DEPTH; i++) step("R7", 1, 8'(i * 7), i == DEPTH - 1, 0, 0, 0, 0);
    chk("R7", "full uncommitted", full, 1);
    step("R7", 0, 8'h00, 0, 1, 0, 0, 0);
    step("R7", 1, 8'hEE, 0, 0, 0, 0, 0);
    chk("R7", "overrun error", ovf_err, 1);
    step("R9", 0, 8'h00, 0, 0, 0, 0, 1);
    step("R9", 1, 8'hDD, 1, 1, 0, 0, 0);
    step("R8", 0, 8'h00, 0, 0, 0, 0, 0);
    chk("R8", "error sticky", ovf_err, 1);
    step("R8", 0, 8'h00, 0, 0, 0, 1, 0);
    chk("R8", "error cleared", ovf_err, 0);
    drain("R9");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit w, c, rw, cl, r, l;
      w  = ($urandom % 100) < 55;
      l  = ($urandom % 100) < 20;
      c  = ($urandom % 100) < 12;
      rw = ($urandom % 100) < 5;
      cl = m_err && (($urandom % 100) < 25);
      r  = ($urandom % 100) < ((i / 500) % 2 == 0 ? 25 : 60);
      step("R2", w, 8'($urandom), l, c, rw, cl, r);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule